// File: doc/BRIEF.md
# Retriggerable Interrupt Delay Timer

This block holds back the posting of one interrupt source for a fixed number of clock cycles after a triggering event. A software service loop that drains a queue can then finish its work before the next request reaches it. A schedule strobe arms the countdown with the full interval. A second schedule strobe, arriving while the countdown runs, restarts it from the full interval. A cancel strobe disarms it.

When the countdown reaches its end, the block looks at the source's live enable bit. If the bit is set, it emits a one-cycle fire pulse, which the surrounding logic uses to set the pending status bit. If the bit is clear, nothing happens. A fire-now strobe makes the same enable check and emits the same pulse at once, without waiting.

The block also counts the cycles since its last pulse. This counter saturates, and a window flag derived from it lets the caller choose between firing at once and scheduling a delayed fire. The default delay of 45 cycles gives 225 ns at a 200 MHz clock.

Top module: `irq_delay_timer`

## Requirements
- R1: After reset, `armed` is 0, `remaining` is 0, `firePulse` is 0 and `sinceFire` holds its maximum value (all ones).
- R2: A schedule strobe while idle sets `armed` and loads `remaining` with DelayCycles on the same edge. The count then drops by one per cycle, and `firePulse` is high in the cycle after the edge that takes `remaining` from 1 to 0, which is exactly DelayCycles edges after the schedule edge.
- R3: A schedule strobe while `armed` is high reloads `remaining` with DelayCycles. It does not continue the old count.
- R4: When the countdown expires, `armed` and `remaining` both return to 0. `firePulse` goes high for one cycle only if `srcEnable` is 1 in the cycle of expiry. If `srcEnable` is 0 in that cycle, no pulse is produced.
- R5: A cancel strobe clears `armed` and `remaining` on the next edge. If schedule and cancel arrive in the same cycle, cancel wins and the block ends up disarmed.
- R6: A fire-now strobe with `srcEnable` at 1 produces `firePulse` after the next edge. With `srcEnable` at 0 it produces no pulse. In either case it leaves an armed countdown running unchanged.
- R7: `sinceFire` reads 0 in the cycle where `firePulse` is high, then rises by one each cycle.
- R8: `sinceFire` stops at its maximum value and does not wrap.
- R9: `windowOpen` is 1 exactly when `sinceFire` is greater than DelayCycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| schedReq | input | 1 | Arm or restart the countdown |
| cancelReq | input | 1 | Disarm the countdown |
| fireNowReq | input | 1 | Fire without delay, subject to the enable bit |
| srcEnable | input | 1 | Live enable bit of this interrupt source |
| firePulse | output | 1 | One-cycle pulse that sets the pending status bit |
| armed | output | 1 | A countdown is running |
| remaining | output | CntW | Cycles left in the countdown |
| sinceFire | output | AgeW | Saturating count of cycles since the last pulse |
| windowOpen | output | 1 | More than DelayCycles cycles have passed since the last pulse |

## Verification
The bench builds the block with DelayCycles set to 4. This makes the countdown counter 3 bits wide and the since-fire counter 3 bits wide, with a maximum of 7. With such a short interval, the bench can step through a full countdown, a restart in the middle of a count, and an expiry while the source is disabled, all cycle by cycle. It also drives the since-fire counter past the window threshold and into saturation within a handful of cycles.

// File: rtl/irq_delay_pkg.sv
package irq_delay_pkg;
  typedef struct packed {
    logic clear;
    logic load;
    logic dec;
    logic post;
  } dlyStrobes_t;
endpackage

// File: rtl/irq_delay_ctrl.sv
module irq_delay_ctrl
  import irq_delay_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        schedReq,
  input  logic        cancelReq,
  input  logic        fireNowReq,
  input  logic        srcEnable,
  input  logic        lastTick,
  output logic        armed,
  output dlyStrobes_t strb
);
  logic armedQ;
  logic expire;

  always_comb begin
    strb.clear = cancelReq;
    strb.load  = !cancelReq && schedReq;
    strb.dec   = !cancelReq && !schedReq && armedQ;
    expire     = strb.dec && lastTick;
    strb.post  = (expire || fireNowReq) && srcEnable;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           armedQ <= 1'b0;
    else if (strb.clear) armedQ <= 1'b0;
    else if (strb.load)  armedQ <= 1'b1;
    else if (expire)     armedQ <= 1'b0;
  end

  assign armed = armedQ;
endmodule

// File: rtl/irq_delay_dp.sv
module irq_delay_dp
  import irq_delay_pkg::*;
#(
  parameter int DelayCycles = 45,
  parameter int CntW = $clog2(DelayCycles + 1),
  parameter int AgeW = $clog2(DelayCycles + 2)
) (
  input  logic            clk,
  input  logic            rstN,
  input  dlyStrobes_t     strb,
  output logic            lastTick,
  output logic            firePulse,
  output logic [CntW-1:0] remaining,
  output logic [AgeW-1:0] sinceFire,
  output logic            windowOpen
);
  localparam logic [CntW-1:0] LoadVal = CntW'(DelayCycles);
  localparam logic [AgeW-1:0] AgeMax  = {AgeW{1'b1}};
  localparam logic [AgeW-1:0] AgeThr  = AgeW'(DelayCycles);

  logic [CntW-1:0] cntQ;
  logic [AgeW-1:0] ageQ;
  logic            fireQ;

  always_ff @(posedge clk) begin
    if (!rstN)           cntQ <= '0;
    else if (strb.clear) cntQ <= '0;
    else if (strb.load)  cntQ <= LoadVal;
    else if (strb.dec)   cntQ <= cntQ - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fireQ <= 1'b0;
      ageQ  <= AgeMax;
    end else begin
      fireQ <= strb.post;
      if (strb.post)           ageQ <= '0;
      else if (ageQ != AgeMax) ageQ <= ageQ + 1'b1;
    end
  end

  assign lastTick   = (cntQ == CntW'(1));
  assign firePulse  = fireQ;
  assign remaining  = cntQ;
  assign sinceFire  = ageQ;
  assign windowOpen = (ageQ > AgeThr);
endmodule

// File: rtl/irq_delay_timer.sv
module irq_delay_timer
  import irq_delay_pkg::*;
#(
  parameter int DelayCycles = 45,
  parameter int CntW = $clog2(DelayCycles + 1),
  parameter int AgeW = $clog2(DelayCycles + 2)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            schedReq,
  input  logic            cancelReq,
  input  logic            fireNowReq,
  input  logic            srcEnable,
  output logic            firePulse,
  output logic            armed,
  output logic [CntW-1:0] remaining,
  output logic [AgeW-1:0] sinceFire,
  output logic            windowOpen
);
  dlyStrobes_t strb;
  logic        lastTick;

  irq_delay_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .schedReq(schedReq), .cancelReq(cancelReq),
    .fireNowReq(fireNowReq), .srcEnable(srcEnable), .lastTick(lastTick),
    .armed(armed), .strb(strb)
  );

  irq_delay_dp #(.DelayCycles(DelayCycles), .CntW(CntW), .AgeW(AgeW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .lastTick(lastTick),
    .firePulse(firePulse), .remaining(remaining), .sinceFire(sinceFire),
    .windowOpen(windowOpen)
  );
endmodule

// File: rtl/irq_delay_timer_chk.sv
module irq_delay_timer_chk #(
  parameter int DelayCycles = 45,
  parameter int CntW = 6,
  parameter int AgeW = 6
) (
  input logic            clk,
  input logic            rstN,
  input logic            schedReq,
  input logic            cancelReq,
  input logic            fireNowReq,
  input logic            srcEnable,
  input logic            firePulse,
  input logic            armed,
  input logic [CntW-1:0] remaining,
  input logic [AgeW-1:0] sinceFire
);
  localparam logic [AgeW-1:0] AgeMax = {AgeW{1'b1}};

  p_load_full_r2: assert property (@(posedge clk) disable iff (!rstN)
    (schedReq && !cancelReq) |=> (armed && remaining == CntW'(DelayCycles)));

  // R3: a running count, with no new request, only steps down by one
  p_step_down_r3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && remaining > 1 && !schedReq && !cancelReq)
      |=> (armed && remaining == $past(remaining) - 1'b1));

  p_armed_nonzero_r4: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (remaining != '0));

  p_pulse_needs_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
    firePulse |-> $past(srcEnable));

  p_cancel_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    cancelReq |=> (!armed && remaining == '0));

  p_fire_now_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fireNowReq && srcEnable) |=> firePulse);

  p_age_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    firePulse |-> (sinceFire == '0));

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sinceFire == AgeMax) |=> (sinceFire == AgeMax || firePulse));
endmodule

bind irq_delay_timer irq_delay_timer_chk #(
  .DelayCycles(DelayCycles), .CntW(CntW), .AgeW(AgeW)
) u_chk (
  .clk(clk), .rstN(rstN), .schedReq(schedReq), .cancelReq(cancelReq),
  .fireNowReq(fireNowReq), .srcEnable(srcEnable), .firePulse(firePulse),
  .armed(armed), .remaining(remaining), .sinceFire(sinceFire)
);

// File: tb/tb_irq_delay_timer.sv
module tb_irq_delay_timer;
  localparam int D  = 4;
  localparam int CW = $clog2(D + 1);
  localparam int AW = $clog2(D + 2);
  localparam int NV = 22;

  // Vector bits: [8]sched [7]cancel [6]now [5]enable | [4]fire [3]armed [2:0]remaining after the edge
  localparam logic [8:0] VEC [NV] = '{
    9'b1001_0_1_100, // R2 arm from idle
    9'b0001_0_1_011,
    9'b0001_0_1_010,
    9'b0001_0_1_001,
    9'b0001_1_0_000, // R2 R4 expiry with enable
    9'b0001_0_0_000, // R4 single-cycle pulse
    9'b1001_0_1_100,
    9'b0001_0_1_011,
    9'b1001_0_1_100, // R3 restart
    9'b0001_0_1_011,
    9'b0001_0_1_010,
    9'b0000_0_1_001,
    9'b0000_0_0_000, // R4 expiry with enable low
    9'b1001_0_1_100,
    9'b0101_0_0_000, // R5 cancel
    9'b1101_0_0_000, // R5 cancel beats schedule
    9'b0011_1_0_000, // R6 fire now
    9'b0010_0_0_000, // R6 fire now with enable low
    9'b0001_0_0_000,
    9'b1001_0_1_100,
    9'b0011_1_1_011, // R6 fire now keeps countdown
    9'b0001_0_1_010
  };

  logic clk = 1'b0;
  logic rstN, schedReq, cancelReq, fireNowReq, srcEnable;
  logic firePulse, armed, windowOpen;
  logic [CW-1:0] remaining;
  logic [AW-1:0] sinceFire;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_delay_timer #(.DelayCycles(D)) dut (
    .clk(clk), .rstN(rstN), .schedReq(schedReq), .cancelReq(cancelReq),
    .fireNowReq(fireNowReq), .srcEnable(srcEnable), .firePulse(firePulse),
    .armed(armed), .remaining(remaining), .sinceFire(sinceFire),
    .windowOpen(windowOpen)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic s, input logic c, input logic n, input logic e);
    schedReq = s; cancelReq = c; fireNowReq = n; srcEnable = e;
    @(posedge clk);
    #1;
  endtask

  initial begin
    rstN = 1'b0; schedReq = 0; cancelReq = 0; fireNowReq = 0; srcEnable = 1;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    chk("R1 armed", armed, 0);
    chk("R1 remaining", remaining, 0);
    chk("R1 firePulse", firePulse, 0);
    chk("R1 sinceFire", sinceFire, 7);
    chk("R9 windowOpen after reset", windowOpen, 1);

    for (int i = 0; i < NV; i++) begin
      tick(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5]);
      chk($sformatf("R2-vector%0d fire", i), firePulse, VEC[i][4]);
      chk($sformatf("R2-vector%0d armed", i), armed, VEC[i][3]);
      chk($sformatf("R2-vector%0d remaining", i), remaining, VEC[i][2:0]);
    end

    // R7 / R8 / R9: age after a fire-now pulse
    tick(0, 1, 1, 1);
    chk("R7 age zero on pulse", sinceFire, 0);
    chk("R9 window closed", windowOpen, 0);
    for (int k = 1; k <= 4; k++) tick(0, 0, 0, 1);
    chk("R7 age counts", sinceFire, 4);
    chk("R9 window closed at D", windowOpen, 0);
    tick(0, 0, 0, 1);
    chk("R9 window opens past D", windowOpen, 1);
    for (int k = 0; k < 5; k++) tick(0, 0, 0, 1);
    chk("R8 age saturates", sinceFire, 7);
    chk("R8 no pulse", firePulse, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule